// File: doc/BRIEF.md
# Accumulator Requantisation Pipeline

This block takes a signed 32-bit accumulator word and turns it into a signed 8-bit result in three pipelined steps. First it adds a signed 8-bit offset. Then it applies an activation that is picked by a two-bit selector. Last, it shifts the value right arithmetically by a programmable amount and clamps it to the 8-bit signed range. It sits after a multiply-accumulate datapath in a quantised inference engine. The offset, the activation selector and the shift amount are configuration values held in registers and are treated as static while data is in flight.

Data enters and leaves through valid/ready handshakes. When the consumer does not accept the output, the whole pipeline freezes and holds its contents. An empty flag reports when no stage holds data.

Top module: `requant_pipe`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, empty is 1 and in_ready is 1.
- R2: The bias is sign-extended and added to the sign-extended accumulator at 33-bit precision, so the sum never wraps (for example 0x7FFFFFFF + 127 with shift 31 gives 1).
- R3: act_mode 2'b00 and 2'b11 both pass the biased value through unchanged.
- R4: act_mode 2'b01 replaces a negative biased value with zero and passes non-negative values through.
- R5: act_mode 2'b10 replaces a negative biased value with its arithmetic right shift by 3 (rounding toward minus infinity, so -1 gives -1 and -9 gives -2) and passes non-negative values through.
- R6: The activated value is shifted right arithmetically by quant_shift (0 to 31) and then saturated to the range -128 to 127.
- R7: A word accepted on a rising edge (in_valid and in_ready both high) appears on out_valid/out_data after the third rising edge, counting the accepting edge, provided the pipeline is not stalled.
- R8: While out_valid is high and out_ready is low, in_ready is low, out_data holds its value, no data is lost or reordered, and in_valid is ignored.
- R9: empty is high exactly when none of the three stages holds a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Pipeline accepts a word on this edge |
| in_data | input | 32 | Signed accumulator value |
| bias | input | 8 | Signed offset (static configuration) |
| act_mode | input | 2 | Activation select: 00 none, 01 ReLU, 10 leaky, 11 none |
| quant_shift | input | 5 | Right-shift amount 0 to 31 |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 8 | Signed saturated result |
| empty | output | 1 | No stage holds data |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, an 8-bit bias and output, and a 5-bit shift. With these widths the extreme accumulator values combined with extreme biases and a shift of 31 are reachable, so the 33-bit sum and both saturation limits are exercised exactly. A stall sequence fills all three stages with the output blocked, then drains them, to check order, holding and the empty flag.

// File: rtl/requant_pkg.sv
// Shared types for the requantisation pipeline.
// Assumes: activation selector is two bits wide.
package requant_pkg;
    typedef enum logic [1:0] {
        ACT_PASS     = 2'b00,
        ACT_RELU     = 2'b01,
        ACT_LEAKY    = 2'b10,
        ACT_PASS_ALT = 2'b11
    } act_sel_e;

    // Leaky slope is 2^-LEAKY_SH
    localparam int LEAKY_SH = 3;
endpackage

// File: rtl/rq_bias_stage.sv
// Stage one: sign-extends accumulator and bias and adds them at full
// precision (one extra bit), so the sum cannot wrap.
// Assumes: bias is stable while data is in flight.
module rq_bias_stage #(
    parameter int ACC_W  = 32,
    parameter int BIAS_W = 8,
    localparam int SUM_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    vin,
    input  logic [ACC_W-1:0]        din,
    input  logic [BIAS_W-1:0]       bias,
    output logic                    vout,
    output logic signed [SUM_W-1:0] dout
);
    logic signed [SUM_W-1:0] acc_ext;
    logic signed [SUM_W-1:0] bias_ext;

    // Widen both operands with their sign bits
    always_comb begin
        acc_ext  = SUM_W'($signed(din));
        bias_ext = SUM_W'($signed(bias));
    end

    // Register the sum whenever the pipeline advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else if (adv) begin
            vout <= vin;
            dout <= acc_ext + bias_ext;
        end
    end
endmodule

// File: rtl/rq_act_stage.sv
// Stage two: applies the selected activation to the biased value.
// Assumes: mode is stable while data is in flight; 11 behaves as 00.
module rq_act_stage
    import requant_pkg::*;
#(
    parameter int SUM_W = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    vin,
    input  logic signed [SUM_W-1:0] din,
    input  logic [1:0]              mode,
    output logic                    vout,
    output logic signed [SUM_W-1:0] dout
);
    logic signed [SUM_W-1:0] act_val;
    logic                    is_neg;

    // Select activation result
    always_comb begin
        is_neg = din[SUM_W-1];
        unique case (act_sel_e'(mode))
            ACT_RELU:  act_val = is_neg ? '0 : din;
            ACT_LEAKY: act_val = is_neg ? (din >>> LEAKY_SH) : din;
            default:   act_val = din;
        endcase
    end

    // Register activation output on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else if (adv) begin
            vout <= vin;
            dout <= act_val;
        end
    end
endmodule

// File: rtl/rq_quant_stage.sv
// Stage three: arithmetic right shift by a programmable amount, then
// signed saturation to the output width.
// Assumes: shift amount is stable while data is in flight.
module rq_quant_stage #(
    parameter int SUM_W   = 33,
    parameter int OUT_W   = 8,
    parameter int SHIFT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    vin,
    input  logic signed [SUM_W-1:0] din,
    input  logic [SHIFT_W-1:0]      shamt,
    output logic                    vout,
    output logic [OUT_W-1:0]        dout
);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [SUM_W-1:0] shifted;
    logic [OUT_W-1:0]        sat_val;

    // Shift then clamp to the output range
    always_comb begin
        shifted = din >>> shamt;
        if (shifted > SAT_HI)
            sat_val = SAT_HI[OUT_W-1:0];
        else if (shifted < SAT_LO)
            sat_val = SAT_LO[OUT_W-1:0];
        else
            sat_val = shifted[OUT_W-1:0];
    end

    // Register the quantised output on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else if (adv) begin
            vout <= vin;
            dout <= sat_val;
        end
    end
endmodule

// File: rtl/requant_pipe.sv
// Top: three-stage bias / activation / requantisation pipeline with
// valid/ready at both ends. The pipeline moves as a whole: it advances
// when the output slot is free or being taken, otherwise all stages hold.
// Assumes: configuration inputs are static while data is in flight.
module requant_pipe #(
    parameter int ACC_W   = 32,
    parameter int BIAS_W  = 8,
    parameter int OUT_W   = 8,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ACC_W-1:0]   in_data,
    input  logic [BIAS_W-1:0]  bias,
    input  logic [1:0]         act_mode,
    input  logic [SHIFT_W-1:0] quant_shift,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic               empty
);
    localparam int SUM_W = ACC_W + 1;

    logic                    adv;
    logic                    v1, v2;
    logic signed [SUM_W-1:0] d1, d2;

    // Global advance: output slot empty or being consumed
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
        empty    = !(v1 || v2 || out_valid);
    end

    rq_bias_stage #(.ACC_W(ACC_W), .BIAS_W(BIAS_W)) i_bias (
        .clk(clk), .rst_n(rst_n), .adv(adv), .vin(in_valid),
        .din(in_data), .bias(bias), .vout(v1), .dout(d1)
    );

    rq_act_stage #(.SUM_W(SUM_W)) i_act (
        .clk(clk), .rst_n(rst_n), .adv(adv), .vin(v1),
        .din(d1), .mode(act_mode), .vout(v2), .dout(d2)
    );

    rq_quant_stage #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) i_quant (
        .clk(clk), .rst_n(rst_n), .adv(adv), .vin(v2),
        .din(d2), .shamt(quant_shift), .vout(out_valid), .dout(out_data)
    );
endmodule

// File: rtl/requant_pipe_chk.sv
// Checker: handshake, latency, hold and empty properties at the ports.
// Assumes: attached to every requant_pipe instance by the bind below.
module requant_pipe_chk #(
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             empty
);
    // R1: a reset cycle leaves the pipeline empty
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (empty && !out_valid && in_ready));

    // R7: unstalled word emerges after three edges
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
        |-> out_valid);

    // R8: blocked output holds its value
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: blocked output refuses new input
    p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: an empty pipeline presents no output
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !out_valid);

    // R9: an accepted word clears empty
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !empty);
endmodule

bind requant_pipe requant_pipe_chk #(.OUT_W(OUT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .empty(empty)
);

// File: tb/test_requant_pipe.sv
module test_requant_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [7:0]  bias = '0;
    logic [1:0]  act_mode = '0;
    logic [4:0]  quant_shift = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        empty;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    requant_pipe i_requant_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .bias(bias), .act_mode(act_mode),
        .quant_shift(quant_shift), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .empty(empty)
    );

    // {data, bias, mode, shift, expected}
    localparam int NV = 16;
    localparam logic [54:0] VECS [NV] = '{
        {32'd2,          8'h00, 2'b01, 5'd0,  8'h02}, // R4 positive
        {32'hFFFFFFFB,   8'h00, 2'b01, 5'd0,  8'h00}, // R4 negative -> 0
        {32'hFFFFFFFB,   8'h00, 2'b00, 5'd0,  8'hFB}, // R3 mode 00
        {32'hFFFFFFFB,   8'h00, 2'b11, 5'd0,  8'hFB}, // R3 mode 11
        {32'hFFFFFFF7,   8'h00, 2'b10, 5'd0,  8'hFE}, // R5 -9 -> -2
        {32'hFFFFFFFF,   8'h00, 2'b10, 5'd0,  8'hFF}, // R5 -1 -> -1
        {32'd40,         8'h00, 2'b10, 5'd0,  8'd40}, // R5 positive
        {32'd100,        8'hFD, 2'b00, 5'd0,  8'd97}, // R2 negative bias
        {32'd1000,       8'h00, 2'b00, 5'd3,  8'd125},// R6 shift
        {32'd1000,       8'h00, 2'b00, 5'd2,  8'h7F}, // R6 high sat
        {32'hFFFFFC18,   8'h00, 2'b00, 5'd2,  8'h80}, // R6 low sat
        {32'hFFFFFFF9,   8'h00, 2'b00, 5'd1,  8'hFC}, // R6 floor -7>>1
        {32'h7FFFFFFF,   8'h7F, 2'b00, 5'd31, 8'h01}, // R2 no wrap high
        {32'h80000000,   8'h80, 2'b00, 5'd31, 8'hFE}, // R2 no wrap low
        {32'h80000000,   8'h00, 2'b10, 5'd31, 8'hFF}, // R5 leaky extreme
        {32'd256,        8'hFF, 2'b01, 5'd1,  8'h7F}  // R6 exact limit
    };

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one word and check latency and value
    task automatic run_vec(input logic [54:0] v);
        @(negedge clk);
        in_data     = v[54:23];
        bias        = v[22:15];
        act_mode    = v[14:13];
        quant_shift = v[12:8];
        in_valid    = 1'b1;
        @(posedge clk);          // accepting edge
        @(negedge clk);
        in_valid = 1'b0;
        check(!empty, "R9", empty, 0);
        @(posedge clk);          // edge two
        @(negedge clk);
        check(!out_valid, "R7 early", out_valid, 0);
        @(posedge clk);          // edge three
        @(negedge clk);
        check(out_valid, "R7 valid", out_valid, 1);
        check(out_data == v[7:0], "R2-R6 vector value", out_data, v[7:0]);
        @(posedge clk);
        @(negedge clk);
        check(empty && !out_valid, "R9 drained", empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(empty && !out_valid && in_ready, "R1 reset", {empty, out_valid, in_ready}, 3'b101);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8 stall: fill three stages with output blocked
        @(negedge clk);
        bias = '0; act_mode = 2'b00; quant_shift = '0;
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 32'd11;
        @(posedge clk); @(negedge clk);
        in_data = 32'd22;
        @(posedge clk); @(negedge clk);
        in_data = 32'd33;
        @(posedge clk); @(negedge clk);
        in_data = 32'd99;        // offered while blocked: must be ignored
        check(out_valid && out_data == 8'd11, "R8 head", out_data, 11);
        check(!in_ready, "R8 ready low", in_ready, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_data == 8'd11, "R8 held", out_data, 11);
        check(!empty, "R9 full", empty, 0);
        out_ready = 1'b1;
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check(out_valid && out_data == 8'd22, "R8 order 2", out_data, 22);
        @(posedge clk); @(negedge clk);
        check(out_valid && out_data == 8'd33, "R8 order 3", out_data, 33);
        @(posedge clk); @(negedge clk);
        check(!out_valid && empty, "R8 ignored input", out_data, 0);

        // R1 reset mid-flight
        in_valid = 1'b1; in_data = 32'd5;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(empty && !out_valid && in_ready, "R1 mid reset", empty, 1);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule